// File: doc/BRIEF.md
# Answer-to-Reset Convention Detector

This block sits behind a smart-card character receiver. It looks at the first character that arrives after the activation sequencer arms it. That character is the initial TS character, and the block uses it to decide whether the card talks in direct or inverse convention. For the rest of the session, every received character is rewritten into direct convention, so downstream logic and firmware only ever see one encoding.

The TS character also gets an even-parity check. A bad parity can raise a request for the line-level error signal, and the parity check and that request each have their own enable. A TS value that matches neither convention is flagged and leaves the convention undecided. The decided convention stays in force until the sequencer arms the block again or reset is applied. Every character comes out registered, one clock after its input strobe.

Top module: `atr_ts_conv`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, byte_vld_o, ts_o, par_err_o, brk_req_o, conv_known_o, conv_inv_o and ts_bad_o are all 0, and data_o and par_o are 0.
- R2: The first byte strobed after arm_i is the TS character. A byte strobed in the same cycle as arm_i also counts as TS. A raw TS of 0x3B sets conv_known_o=1 and conv_inv_o=0. A raw TS of 0x03 sets conv_known_o=1 and conv_inv_o=1. ts_o is 1 in the output cycle of that byte.
- R3: Under inverse convention with conv_en_i=1, the TS byte and every later byte are converted. Output bit k is the complement of input bit 7-k, and par_o is the complement of par_i.
- R4: With conv_en_i=0, data_o and par_o equal data_i and par_i, whatever convention was detected.
- R5: Under direct convention, or when no convention is known, data and parity pass through unchanged.
- R6: par_err_o pulses in the output cycle of a valid TS when par_chk_en_i=1 and the 9 bits in direct form have an odd number of ones. The direct form is the inverse-converted form whenever the convention is inverse, regardless of conv_en_i. par_err_o never pulses for non-TS bytes.
- R7: brk_req_o pulses exactly when par_err_o pulses and brk_en_i was 1 with that byte.
- R8: A TS other than 0x3B or 0x03 sets ts_bad_o, leaves conv_known_o=0 and is not parity-checked. Later bytes pass unchanged and are not taken as TS.
- R9: conv_known_o, conv_inv_o and ts_bad_o hold until the next arm_i or reset. An arm_i without a byte clears all three in the following cycle.
- R10: byte_vld_o is a one-cycle pulse in the cycle after each byte_vld_i. Between strobes, data_o and par_o hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Start of a new session; next byte is TS |
| byte_vld_i | input | 1 | Received character strobe |
| data_i | input | 8 | Raw received data bits |
| par_i | input | 1 | Raw received parity bit |
| conv_en_i | input | 1 | Enable inverse-to-direct rewriting |
| par_chk_en_i | input | 1 | Enable parity check on TS |
| brk_en_i | input | 1 | Enable error-signal request on TS parity fault |
| byte_vld_o | output | 1 | Output character strobe |
| data_o | output | 8 | Character in direct convention |
| par_o | output | 1 | Parity bit matching data_o |
| ts_o | output | 1 | Output character was the TS |
| conv_known_o | output | 1 | A valid convention has been decided |
| conv_inv_o | output | 1 | Decided convention is inverse |
| par_err_o | output | 1 | TS parity fault pulse |
| brk_req_o | output | 1 | Request to drive the error signal |
| ts_bad_o | output | 1 | TS matched neither convention |

## Verification
The bench builds the block with its defaults: an 8-bit character and the TS codes 0x3B and 0x03. These are the values a real card sends, so both conventions, the full bit reversal of a character and the complemented parity bit are all exercised. Sessions cover direct, inverse and unknown TS characters. In those sessions the conversion, parity-check and error-request enables are toggled, arm coincides with a byte, and bytes arrive before any arm. All outputs are compared each clock against a behavioural model.

// File: rtl/atr_ts_pkg.sv
package atr_ts_pkg;
  typedef enum logic [1:0] {
    TS_NONE = 2'd0,
    TS_DIR  = 2'd1,
    TS_INV  = 2'd2,
    TS_BAD  = 2'd3
  } ts_kind_e;
endpackage

// File: rtl/atr_inv_map.sv
module atr_inv_map #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  output logic [DATA_W-1:0] data_o,
  output logic              par_o
);
  // complement plus bit-order reversal
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign data_o[i] = ~data_i[DATA_W-1-i];
  end
  assign par_o = ~par_i;
endmodule

// File: rtl/atr_par_chk.sv
module atr_par_chk #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  output logic              err_o
);
  // even parity over data and parity bit
  assign err_o = ^{data_i, par_i};
endmodule

// File: rtl/atr_ts_ctrl.sv
module atr_ts_ctrl
  import atr_ts_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] TS_DIRECT  = 'h3B,
  parameter logic [DATA_W-1:0] TS_INVERSE = 'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              is_ts_o,
  output logic              cur_inv_o,
  output logic              cur_known_o,
  output logic              known_o,
  output logic              inv_o,
  output logic              bad_o
);
  logic     wait_q, known_q, inv_q, bad_q;
  ts_kind_e kind;

  assign is_ts_o = byte_vld_i & (arm_i | wait_q);

  always_comb begin
    kind = TS_NONE;
    if (is_ts_o) begin
      if (data_i == TS_DIRECT)       kind = TS_DIR;
      else if (data_i == TS_INVERSE) kind = TS_INV;
      else                           kind = TS_BAD;
    end
  end

  // convention that applies to the byte at the input this cycle
  assign cur_known_o = is_ts_o ? (kind == TS_DIR || kind == TS_INV) : (known_q & ~arm_i);
  assign cur_inv_o   = is_ts_o ? (kind == TS_INV) : (inv_q & ~arm_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q  <= 1'b0;
      known_q <= 1'b0;
      inv_q   <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      if (arm_i) begin
        wait_q  <= 1'b1;
        known_q <= 1'b0;
        inv_q   <= 1'b0;
        bad_q   <= 1'b0;
      end
      if (is_ts_o) begin
        wait_q  <= 1'b0;
        known_q <= (kind == TS_DIR) || (kind == TS_INV);
        inv_q   <= (kind == TS_INV);
        bad_q   <= (kind == TS_BAD);
      end
    end
  end

  assign known_o = known_q;
  assign inv_o   = inv_q;
  assign bad_o   = bad_q;

  p_dir_ts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ts_o && data_i == TS_DIRECT) |=> (known_q && !inv_q));
  p_inv_ts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ts_o && data_i == TS_INVERSE) |=> (known_q && inv_q));
  p_bad_unknown_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_q |-> !known_q);
  p_hold_conv_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (known_q && !arm_i) |=> (known_q && inv_q == $past(inv_q)));
  p_arm_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !byte_vld_i) |=> (!known_q && !bad_q && !inv_q));
endmodule

// File: rtl/atr_ts_conv.sv
module atr_ts_conv #(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] TS_DIRECT  = 'h3B,
  parameter logic [DATA_W-1:0] TS_INVERSE = 'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              conv_en_i,
  input  logic              par_chk_en_i,
  input  logic              brk_en_i,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_o,
  output logic              ts_o,
  output logic              conv_known_o,
  output logic              conv_inv_o,
  output logic              par_err_o,
  output logic              brk_req_o,
  output logic              ts_bad_o
);
  logic              is_ts, cur_inv, cur_known, par_bad;
  logic [DATA_W-1:0] inv_data, dir_data, out_data;
  logic              inv_par, dir_par, out_par;
  logic              vld_q, ts_q, perr_q, brk_q, par_q;
  logic [DATA_W-1:0] data_q;

  atr_ts_ctrl #(
    .DATA_W(DATA_W), .TS_DIRECT(TS_DIRECT), .TS_INVERSE(TS_INVERSE)
  ) u_ctrl (
    .clk_i, .rst_ni, .arm_i, .byte_vld_i, .data_i,
    .is_ts_o(is_ts), .cur_inv_o(cur_inv), .cur_known_o(cur_known),
    .known_o(conv_known_o), .inv_o(conv_inv_o), .bad_o(ts_bad_o)
  );

  atr_inv_map #(.DATA_W(DATA_W)) u_map (
    .data_i, .par_i, .data_o(inv_data), .par_o(inv_par)
  );

  // parity is judged in direct form even if rewriting is off
  assign dir_data = cur_inv ? inv_data : data_i;
  assign dir_par  = cur_inv ? inv_par  : par_i;

  atr_par_chk #(.DATA_W(DATA_W)) u_par (
    .data_i(dir_data), .par_i(dir_par), .err_o(par_bad)
  );

  assign out_data = (cur_inv && conv_en_i) ? inv_data : data_i;
  assign out_par  = (cur_inv && conv_en_i) ? inv_par  : par_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      ts_q   <= 1'b0;
      perr_q <= 1'b0;
      brk_q  <= 1'b0;
      data_q <= '0;
      par_q  <= 1'b0;
    end else begin
      vld_q  <= byte_vld_i;
      ts_q   <= is_ts;
      perr_q <= is_ts & cur_known & par_chk_en_i & par_bad;
      brk_q  <= is_ts & cur_known & par_chk_en_i & par_bad & brk_en_i;
      if (byte_vld_i) begin
        data_q <= out_data;
        par_q  <= out_par;
      end
    end
  end

  assign byte_vld_o = vld_q;
  assign ts_o       = ts_q;
  assign par_err_o  = perr_q;
  assign brk_req_o  = brk_q;
  assign data_o     = data_q;
  assign par_o      = par_q;

  p_vld_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(byte_vld_i));
  p_hold_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> $stable(data_o));
  p_perr_ts_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> (ts_o && conv_known_o));
  p_perr_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> $past(par_chk_en_i));
  p_brk_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> (par_err_o && $past(brk_en_i)));
endmodule

// File: tb/atr_ts_conv_test.sv
`timescale 1ns/100ps
module atr_ts_conv_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm = 1'b0, bv = 1'b0, par = 1'b0;
  logic [7:0] din = 8'h00;
  logic       cen = 1'b1, pen = 1'b1, ben = 1'b1;
  logic       vo, po, tso, kno, invo, peo, bro, bado;
  logic [7:0] dout;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  atr_ts_conv uut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .byte_vld_i(bv), .data_i(din),
    .par_i(par), .conv_en_i(cen), .par_chk_en_i(pen), .brk_en_i(ben),
    .byte_vld_o(vo), .data_o(dout), .par_o(po), .ts_o(tso),
    .conv_known_o(kno), .conv_inv_o(invo), .par_err_o(peo),
    .brk_req_o(bro), .ts_bad_o(bado)
  );

  // behavioural reference
  bit m_wait, m_known, m_inv, m_bad;
  bit e_vld, e_ts, e_perr, e_brk, e_par;
  int e_data;

  function automatic int rev_cpl(int d);
    int r = 0;
    for (int i = 0; i < 8; i++) if (((d >> (7 - i)) & 1) == 0) r += (1 << i);
    return r;
  endfunction

  function automatic int ones(int d);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (d >> i) & 1;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wait = 0; m_known = 0; m_inv = 0; m_bad = 0;
      e_vld = 0; e_ts = 0; e_perr = 0; e_brk = 0; e_par = 0; e_data = 0;
    end else begin
      bit use_inv, known_now;
      int dd, pp;
      e_vld = 0; e_ts = 0; e_perr = 0; e_brk = 0;
      if (arm) begin m_wait = 1; m_known = 0; m_inv = 0; m_bad = 0; end
      if (bv) begin
        if (m_wait) begin
          m_wait = 0; e_ts = 1;
          m_known = (din == 8'h3B) || (din == 8'h03);
          m_inv   = (din == 8'h03);
          m_bad   = !m_known;
        end
        use_inv = m_inv; known_now = m_known;
        dd = use_inv ? rev_cpl(din) : din;
        pp = use_inv ? !par : par;
        if (e_ts && known_now && pen && ((ones(dd) + pp) % 2 == 1)) begin
          e_perr = 1; e_brk = ben;
        end
        if (use_inv && cen) begin e_data = dd; e_par = pp; end
        else begin e_data = din; e_par = par; end
        e_vld = 1;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(vo, e_vld, "R10 byte_vld_o");
      chk(dout, e_data, "R3 data_o");
      chk(po, e_par, "R3 par_o");
      chk(tso, e_ts, "R2 ts_o");
      chk(kno, m_known, "R2 conv_known_o");
      chk(invo, m_inv, "R9 conv_inv_o");
      chk(peo, e_perr, "R6 par_err_o");
      chk(bro, e_brk, "R7 brk_req_o");
      chk(bado, m_bad, "R8 ts_bad_o");
    end
  end

  task automatic send(input logic [7:0] d, input logic p, input logic a);
    @(negedge clk);
    din = d; par = p; bv = 1'b1; arm = a;
    @(negedge clk);
    bv = 1'b0; arm = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  function automatic logic gp(input logic [7:0] d, input bit inv);
    return inv ? ~(^d) : ^d;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    #1;
    // R1 reset values
    chk({vo, tso, kno, invo, peo, bro, bado, po}, 0, "R1 reset flags");
    chk(dout, 0, "R1 reset data");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk({vo, kno, bado}, 0, "R1 after release");

    // R5 no convention yet: pass-through
    send(8'hA5, 1'b1, 0);
    @(posedge clk); #1.5; chk(dout, 8'hA5, "R5 raw before arm");

    // direct session
    do_arm();
    send(8'h3B, gp(8'h3B, 0), 0);
    send(8'h12, 1'b1, 0);
    @(posedge clk); #1.5; chk(dout, 8'h12, "R5 direct pass");
    send(8'hF0, 1'b1, 0);  // bad parity, non-TS: no error (R6)

    // inverse session, conversion on
    do_arm();
    send(8'h03, gp(8'h03, 1), 0);
    @(posedge clk); #1.5; chk(dout, 8'h3F, "R3 inverse TS converted");
    send(8'h01, 1'b0, 0);
    @(posedge clk); #1.5; chk(dout, 8'h7F, "R3 inverse byte");
    send(8'hC3, 1'b1, 0);
    send(8'h00, 1'b0, 0);

    // R4 conversion disabled mid-session
    @(negedge clk); cen = 1'b0;
    send(8'h01, 1'b0, 0);
    @(posedge clk); #1.5; chk(dout, 8'h01, "R4 raw with conv off");
    cen = 1'b1;

    // R6/R7 parity fault on inverse TS, arm same cycle as byte
    send(8'h03, 1'b0, 1);
    send(8'h55, 1'b0, 0);
    // R7 break disabled
    @(negedge clk); ben = 1'b0;
    send(8'h3B, 1'b0, 1);
    ben = 1'b1;
    // R6 check disabled
    @(negedge clk); pen = 1'b0;
    send(8'h3B, 1'b0, 1);
    pen = 1'b1;
    // inverse TS with conv off, good parity in direct form
    @(negedge clk); cen = 1'b0;
    send(8'h03, 1'b1, 1);
    send(8'h80, 1'b0, 0);
    cen = 1'b1;

    // R8 bad TS, later 0x3B not taken as TS
    do_arm();
    send(8'h3C, 1'b1, 0);
    send(8'h3B, 1'b0, 0);
    send(8'h03, 1'b0, 0);
    @(posedge clk); #1.5; chk(dout, 8'h03, "R8 raw after bad TS");

    // R9 arm alone clears
    do_arm();
    @(posedge clk); #1.5; chk({kno, bado}, 0, "R9 cleared by arm");
    send(8'h03, 1'b1, 0);
    repeat (4) @(negedge clk);
    chk({kno, invo}, 2'b11, "R9 held idle");
    send(8'h11, 1'b0, 0);
    @(negedge clk); rst_n = 1'b0;
    #1; chk({kno, invo}, 0, "R9 cleared by reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule